// File: doc/BRIEF.md
# Configurable Output Macrocell Bank

This block is the output stage of a small programmable logic device. It holds a bank of identical macrocells. Each one takes the OR-sum of its product terms, its own output-enable term and two configuration control bits. From these it produces a pin value, a pin drive enable that stands in for a tri-state buffer, and a feedback bit that returns to the AND array. All cells share one clock, one asynchronous clear term and one synchronous set term.

Each cell's two control bits select one of four modes. The first choice is registered or combinational. The second is active-high or active-low output. The configuration inputs are written as "programmed" flags. A programmed flag pulls its control bit to 0. An erased flag lets the control bit read 1. An unprogrammed cell is therefore combinational and active-high.

In registered mode the feedback is the inverted register output. In combinational mode the pin works as an I/O. The feedback is taken from the pin, so when the driver is released an external value reaches the array.

Top module: `omc_bank`

## Requirements
- R1: Control bit S0 is the inverse of `pgm_s0[i]` and S1 is the inverse of `pgm_s1[i]`. S1=0 selects registered mode and S1=1 selects combinational mode. S0=1 selects active-high output and S0=0 selects active-low output. A cell with both flags at 0 is combinational active-high.
- R2: In combinational mode, `pin_val[i]` equals `sum_in[i]` when active-high and its inverse when active-low. It follows the input with no clock edge.
- R3: In registered mode the cell's register captures `sum_in[i]` on each rising edge of `clk`. `pin_val[i]` shows the register when active-high and its inverse when active-low.
- R4: In registered mode `fb[i]` is the inverse of the register. It does not depend on polarity or on `oe_term[i]`.
- R5: In combinational mode `fb[i]` equals `pin_val[i]` while `oe_term[i]` is 1. It equals `pin_in[i]` while `oe_term[i]` is 0.
- R6: `pin_oe[i]` equals `oe_term[i]` in every mode.
- R7: While `ar_term` is 1, every register reads 0. The clear takes effect at once, with no clock edge.
- R8: While `sp_term` is 1 at a rising edge, every register loads 1, whatever `sum_in` holds.
- R9: When `ar_term` and `sp_term` are both 1, the registers stay at 0.
- R10: After `ar_term` falls, the registers stay at 0 through the next RST_STAGES rising edges. They load normally from the edge after those.
- R11: Each cell follows its own configuration. Cells set to different modes in the same cycle do not affect one another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared macrocell clock, rising edge |
| ar_term | input | 1 | Asynchronous clear term, active high, shared |
| sp_term | input | 1 | Synchronous set term, active high, shared |
| sum_in | input | N_CELLS | OR-sum from the array, one bit per cell |
| oe_term | input | N_CELLS | Output-enable term per cell |
| pgm_s0 | input | N_CELLS | Programmed flag for the polarity control bit |
| pgm_s1 | input | N_CELLS | Programmed flag for the register/bypass control bit |
| pin_in | input | N_CELLS | Value on the pad when the cell does not drive it |
| pin_val | output | N_CELLS | Value the cell drives onto its pad |
| pin_oe | output | N_CELLS | Pad drive enable |
| fb | output | N_CELLS | Feedback bit returned to the array |

## Verification
The bench builds the bank with N_CELLS=10 and RST_STAGES=2. Each cell's mode is taken from the two low bits of its index. All four modes are therefore live in every cycle, two or three cells each, and the unprogrammed cells sit among programmed ones. With two release stages, the window in which the clear outlives the `ar_term` pulse is short enough to step through edge by edge. The first load edge after that window can then be checked exactly.

// File: rtl/omc_pkg.sv
`timescale 1ns/1ps
package omc_pkg;

  // Mode code is {S1, S0} after the programmed flags are inverted.
  typedef enum logic [1:0] {
    OMC_REG_LOW   = 2'b00,
    OMC_REG_HIGH  = 2'b01,
    OMC_COMB_LOW  = 2'b10,
    OMC_COMB_HIGH = 2'b11
  } omc_mode_e;

  typedef struct packed {
    logic comb;      // 1: bypass the register
    logic act_high;  // 1: drive the true value
  } omc_sel_t;

  function automatic omc_sel_t omc_decode(input omc_mode_e mode);
    omc_sel_t s;
    case (mode)
      OMC_REG_LOW:   s = '{comb: 1'b0, act_high: 1'b0};
      OMC_REG_HIGH:  s = '{comb: 1'b0, act_high: 1'b1};
      OMC_COMB_LOW:  s = '{comb: 1'b1, act_high: 1'b0};
      default:       s = '{comb: 1'b1, act_high: 1'b1};
    endcase
    return s;
  endfunction

endpackage

// File: rtl/omc_rst_sync.sv
`timescale 1ns/1ps
// Asserts the internal active-low clear at once; releases it after STAGES edges.
module omc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic clr_req,
  output logic clr_n
);

  localparam int MSB = STAGES - 1;

  logic [MSB:0] sync_q;
  logic [MSB:0] sync_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb sync_d = 1'b1;
    end else begin : g_chain
      always_comb sync_d = {sync_q[MSB-1:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or posedge clr_req) begin
    if (clr_req) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign clr_n = sync_q[MSB];

endmodule

// File: rtl/omc_cfg_decode.sv
`timescale 1ns/1ps
// A programmed flag pulls its control bit to 0; an erased flag lets it read 1.
module omc_cfg_decode
  import omc_pkg::*;
(
  input  logic     pgm_s0,
  input  logic     pgm_s1,
  output omc_sel_t sel
);

  logic      ctl_s0;
  logic      ctl_s1;
  omc_mode_e mode;

  always_comb begin
    ctl_s0 = ~pgm_s0;
    ctl_s1 = ~pgm_s1;
    mode   = omc_mode_e'({ctl_s1, ctl_s0});
    sel    = omc_decode(mode);
  end

endmodule

// File: rtl/omc_reg_path.sv
`timescale 1ns/1ps
// D register of one cell: async clear, sync set, then data.
module omc_reg_path (
  input  logic clk,
  input  logic clr_n,
  input  logic sum_in,
  input  logic set_in,
  output logic q
);

  logic q_en;
  logic q_nxt;
  logic q_r;

  always_comb begin
    q_en  = 1'b1;
    q_nxt = set_in ? 1'b1 : sum_in;
  end

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      q_r <= 1'b0;
    end else if (q_en) begin
      q_r <= q_nxt;
    end
  end

  assign q = q_r;

endmodule

// File: rtl/omc_out_path.sv
`timescale 1ns/1ps
// Output select, polarity, drive enable and feedback source of one cell.
module omc_out_path
  import omc_pkg::*;
(
  input  omc_sel_t sel,
  input  logic     sum_in,
  input  logic     q_in,
  input  logic     oe_in,
  input  logic     pad_in,
  output logic     pin_val,
  output logic     pin_oe,
  output logic     fb
);

  logic drive_src;
  logic drive_val;
  logic pad_seen;

  always_comb begin
    drive_src = sel.comb ? sum_in : q_in;
    drive_val = sel.act_high ? drive_src : ~drive_src;
    pad_seen  = oe_in ? drive_val : pad_in;
    pin_val   = drive_val;
    pin_oe    = oe_in;
    fb        = sel.comb ? pad_seen : ~q_in;
  end

endmodule

// File: rtl/omc_bank.sv
`timescale 1ns/1ps
module omc_bank
  import omc_pkg::*;
#(
  parameter int N_CELLS    = 10,
  parameter int RST_STAGES = 2
) (
  input  logic               clk,
  input  logic               ar_term,
  input  logic               sp_term,
  input  logic [N_CELLS-1:0] sum_in,
  input  logic [N_CELLS-1:0] oe_term,
  input  logic [N_CELLS-1:0] pgm_s0,
  input  logic [N_CELLS-1:0] pgm_s1,
  input  logic [N_CELLS-1:0] pin_in,
  output logic [N_CELLS-1:0] pin_val,
  output logic [N_CELLS-1:0] pin_oe,
  output logic [N_CELLS-1:0] fb
);

  logic               clr_n;
  logic [N_CELLS-1:0] q_w;

  omc_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk     (clk),
    .clr_req (ar_term),
    .clr_n   (clr_n)
  );

  generate
    for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
      omc_sel_t sel_w;

      omc_cfg_decode u_cfg (
        .pgm_s0 (pgm_s0[i]),
        .pgm_s1 (pgm_s1[i]),
        .sel    (sel_w)
      );

      omc_reg_path u_reg (
        .clk    (clk),
        .clr_n  (clr_n),
        .sum_in (sum_in[i]),
        .set_in (sp_term),
        .q      (q_w[i])
      );

      omc_out_path u_out (
        .sel     (sel_w),
        .sum_in  (sum_in[i]),
        .q_in    (q_w[i]),
        .oe_in   (oe_term[i]),
        .pad_in  (pin_in[i]),
        .pin_val (pin_val[i]),
        .pin_oe  (pin_oe[i]),
        .fb      (fb[i])
      );
    end
  endgenerate

endmodule

// File: rtl/omc_bank_chk.sv
`timescale 1ns/1ps
module omc_bank_chk #(
  parameter int N_CELLS = 10
) (
  input logic               clk,
  input logic               clr_n,
  input logic               sp_term,
  input logic [N_CELLS-1:0] sum_in,
  input logic [N_CELLS-1:0] oe_term,
  input logic [N_CELLS-1:0] pgm_s0,
  input logic [N_CELLS-1:0] pgm_s1,
  input logic [N_CELLS-1:0] pin_in,
  input logic [N_CELLS-1:0] pin_val,
  input logic [N_CELLS-1:0] fb
);

  generate
    for (genvar i = 0; i < N_CELLS; i++) begin : g_chk
      // R2
      comb_pol_chk: assert property (@(negedge clk) disable iff (!clr_n)
        !pgm_s1[i] |-> pin_val[i] == (sum_in[i] ^ pgm_s0[i]));
      // R5
      comb_fb_drive_chk: assert property (@(negedge clk) disable iff (!clr_n)
        (!pgm_s1[i] && oe_term[i]) |-> fb[i] == pin_val[i]);
      // R5
      comb_fb_pad_chk: assert property (@(negedge clk) disable iff (!clr_n)
        (!pgm_s1[i] && !oe_term[i]) |-> fb[i] == pin_in[i]);
      // R3
      reg_pol_chk: assert property (@(negedge clk) disable iff (!clr_n)
        pgm_s1[i] |-> pin_val[i] == (fb[i] ^ ~pgm_s0[i]));
      // R3
      reg_load_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (clr_n && !sp_term) |=> (!pgm_s1[i] || fb[i] == ~$past(sum_in[i])));
      // R8
      reg_set_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (clr_n && sp_term) |=> (!pgm_s1[i] || !fb[i]));

      // R7
      always @(negedge clk) begin
        if (!clr_n && pgm_s1[i]) begin
          reg_clear_chk: assert (fb[i]);
        end
      end
    end
  endgenerate

endmodule

bind omc_bank omc_bank_chk #(.N_CELLS(N_CELLS)) u_omc_chk (
  .clk     (clk),
  .clr_n   (clr_n),
  .sp_term (sp_term),
  .sum_in  (sum_in),
  .oe_term (oe_term),
  .pgm_s0  (pgm_s0),
  .pgm_s1  (pgm_s1),
  .pin_in  (pin_in),
  .pin_val (pin_val),
  .fb      (fb)
);

// File: tb/omc_bank_bench.sv
`timescale 1ns/1ps
module omc_bank_bench;

  localparam int N  = 10;
  localparam int RS = 2;

  logic         clk;
  logic         ar_term;
  logic         sp_term;
  logic [N-1:0] sum_in;
  logic [N-1:0] oe_term;
  logic [N-1:0] pgm_s0;
  logic [N-1:0] pgm_s1;
  logic [N-1:0] pin_in;
  logic [N-1:0] pin_val;
  logic [N-1:0] pin_oe;
  logic [N-1:0] fb;

  int           n_checks;
  int           n_fails;
  bit           done;
  logic [N-1:0] mq;     // expected register state per cell
  int           hold;   // edges still cleared after release (R10)

  omc_bank #(.N_CELLS(N), .RST_STAGES(RS)) u_omc_bank (
    .clk     (clk),
    .ar_term (ar_term),
    .sp_term (sp_term),
    .sum_in  (sum_in),
    .oe_term (oe_term),
    .pgm_s0  (pgm_s0),
    .pgm_s1  (pgm_s1),
    .pin_in  (pin_in),
    .pin_val (pin_val),
    .pin_oe  (pin_oe),
    .fb      (fb)
  );

  // 200 MHz
  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // One clock edge with the given inputs; expected register follows R7..R10.
  task automatic step(input logic [N-1:0] s, input logic sp);
    sum_in  = s;
    sp_term = sp;
    @(posedge clk);
    if (ar_term) begin
      mq = '0;
    end else if (hold > 0) begin
      mq = '0;
      hold--;
    end else begin
      mq = sp ? '1 : s;
    end
    #1;
  endtask

  // Compare all outputs with values derived from R1..R6.
  task automatic check(input string tag);
    logic [N-1:0] ev;
    logic [N-1:0] ef;
    #1;
    for (int i = 0; i < N; i++) begin
      logic c_s0;
      logic c_s1;
      c_s0 = ~pgm_s0[i];
      c_s1 = ~pgm_s1[i];
      if (c_s1) begin
        ev[i] = c_s0 ? sum_in[i] : ~sum_in[i];
        ef[i] = oe_term[i] ? ev[i] : pin_in[i];
      end else begin
        ev[i] = c_s0 ? mq[i] : ~mq[i];
        ef[i] = ~mq[i];
      end
    end
    n_checks++;
    if (pin_val !== ev || fb !== ef || pin_oe !== oe_term) begin
      n_fails++;
      $display("FAIL %s: pin_val=%h fb=%h pin_oe=%h expected pin_val=%h fb=%h pin_oe=%h",
               tag, pin_val, fb, pin_oe, ev, ef, oe_term);
    end
  endtask

  task automatic mixed_cfg();
    for (int i = 0; i < N; i++) begin
      pgm_s0[i] = ~i[0];
      pgm_s1[i] = ~i[1];
    end
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    #1;
    check("R7 R1 reset state, mixed modes");
  endtask

  task automatic t_release();
    step('1, 1'b0);
    ar_term = 1'b0;
    hold    = RS;
    step('1, 1'b0);
    check("R10 first edge after release");
    step('1, 1'b0);
    check("R10 second edge after release");
    step('1, 1'b0);
    check("R10 first load edge");
  endtask

  task automatic t_load();
    step(10'h155, 1'b0);
    check("R3 R4 load 155");
    oe_term = 10'h0F0;
    step(10'h2AA, 1'b0);
    check("R3 R4 R6 load 2AA partial oe");
    oe_term = '1;
    step(10'h3C3, 1'b0);
    check("R2 R3 load 3C3");
  endtask

  task automatic t_comb_fb();
    oe_term = '0;
    pin_in  = 10'h2B9;
    step(10'h0F5, 1'b0);
    check("R5 released pads 2B9");
    pin_in = 10'h146;
    check("R5 released pads 146");
    oe_term = 10'h333;
    sum_in  = 10'h1E1;
    check("R5 R6 mixed drive");
    oe_term = '1;
    pin_in  = '0;
  endtask

  task automatic t_preset();
    step('0, 1'b1);
    check("R8 set loads ones over zero sum");
  endtask

  task automatic t_async();
    step(10'h2D2, 1'b0);
    ar_term = 1'b1;
    mq      = '0;
    check("R7 clear without edge");
  endtask

  task automatic t_priority();
    step('1, 1'b1);
    check("R9 clear beats set, edge 1");
    step('1, 1'b1);
    check("R9 clear beats set, edge 2");
    ar_term = 1'b0;
    hold    = RS;
    step('0, 1'b0);
    step('0, 1'b0);
    step(10'h0AB, 1'b0);
    check("R10 load after second release");
  endtask

  task automatic t_indep();
    pgm_s1 = '1;
    pgm_s0 = '1;
    step(10'h1C7, 1'b0);
    check("R11 all registered active-low");
    pgm_s1 = '0;
    pgm_s0 = 10'h2A5;
    sum_in = 10'h0D3;
    check("R11 R1 comb with per-cell polarity");
  endtask

  initial begin
    n_checks = 0;
    n_fails  = 0;
    done     = 1'b0;
    hold     = 0;
    mq       = '0;
    ar_term  = 1'b1;
    sp_term  = 1'b0;
    sum_in   = '0;
    oe_term  = '1;
    pin_in   = '0;
    mixed_cfg();
    t_reset();
    t_release();
    t_load();
    t_comb_fb();
    t_preset();
    t_async();
    t_priority();
    mixed_cfg();
    t_indep();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule